// File: doc/BRIEF.md
# Ethernet Receive Destination Filter

This block judges every received frame by its 48-bit destination address and returns an accept or drop verdict with a code that gives the reason. A configuration port writes a bank of exact-match slots, a 64-bin multicast hash table and a small control word. The parser upstream presents the destination address with a one-cycle strobe. The verdict comes out of a register on the following clock edge.

The address enters as a 48-bit vector. The first byte on the wire sits in bits 7:0 and the sixth byte sits in bits 47:40. An address is multicast when bit 0 is set, and it is broadcast when all 48 bits are ones. Slot 0 normally holds the station's own address. A control field sets how many low-numbered slots may match unicast addresses, and the slots above that count match only multicast addresses. Multicast addresses that miss every slot fall through to the hash table, whose index is a 6-bit XOR fold of the address.

Top module: `eth_da_filter`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `da_valid` high. `res_accept` is high exactly when the registered reason is not 0. The reason codes are 0 drop, 1 exact-slot hit, 2 hash hit, and 3 broadcast or open mode.
- R2: Slot i has two words. The word at address 0x10+2i holds address bits 31:0. The word at 0x11+2i holds address bits 47:32 in its bits 15:0 and the slot enable in bit 31. An enabled slot whose stored address equals the presented one gives reason 1.
- R3: A disabled slot never matches. After reset every slot is disabled, both hash words (addresses 0x01 low and 0x02 high) are zero, the control bits are clear and the unicast count is 1.
- R4: The control word is at address 0x00, with the unicast count in bits 7:4. A slot whose index is below the count matches any address. A slot at or above the count matches only a multicast address.
- R5: A control write whose count field exceeds 8 leaves the count unchanged. Its other control bits still take effect.
- R6: The hash index sets bit k to the XOR of all address bits n with n mod 6 = k. Indices 0 to 31 select that bit of the low word, and indices 32 to 63 select bit index-32 of the high word. A set bit gives reason 2 only while control bit 1 (hash enable) is set, and only for a multicast, non-broadcast address that hits no slot.
- R7: The all-ones address is accepted with reason 3 unless control bit 2 (broadcast reject) is set.
- R8: While control bit 0 (open mode) is set, every frame is accepted, with reason 3 when nothing else matched.
- R9: The priority order is slot hit, then broadcast, then hash hit, then open mode.
- R10: A configuration write in the same cycle as a strobe affects only later lookups.
- R11: With hash enable set and both hash words all ones, every non-broadcast multicast address is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | AW (6) | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, first wire byte in bits 7:0 |
| res_valid | output | 1 | Verdict valid |
| res_accept | output | 1 | Frame accepted |
| res_reason | output | 2 | Reason code |

## Verification
The hardest case to reach from the ports is a hash verdict, because a hash bit only counts after the XOR fold and only for a multicast address that misses every slot. The stimulus uses addresses whose fold indices were worked out by hand: one lands in the low word and one in the high word, while a near neighbour folds to an unset bin. The other hard case is a write that collides with a lookup. The bench raises the strobe and a slot-disable write on the same clock edge, then repeats the lookup to show the old verdict first and the new one after.

// File: rtl/eth_daf_pkg.sv
package eth_daf_pkg;
   typedef enum logic [1:0] {
      RSN_DROP  = 2'd0,
      RSN_EXACT = 2'd1,
      RSN_HASH  = 2'd2,
      RSN_OPEN  = 2'd3
   } reason_e;

   localparam int CTRL_ADDR  = 0;
   localparam int HASH_BASE  = 1;
   localparam int ENTRY_BASE = 16;
   localparam int CNT_LSB    = 4;
   localparam int CNT_W      = 4;
   localparam int DA_W       = 48;
endpackage

// File: rtl/eth_daf_hash.sv
module eth_daf_hash #(
   parameter int ADDR_W = 48,
   parameter int IDX_W  = 6
) (
   input  logic [ADDR_W-1:0] da,
   output logic [IDX_W-1:0]  idx
);
   // fold: address bit n lands on index bit n mod IDX_W
   always_comb begin
      idx = '0;
      for (int n = 0; n < ADDR_W; n++)
         idx[n % IDX_W] = idx[n % IDX_W] ^ da[n];
   end
endmodule

// File: rtl/eth_daf_exact.sv
module eth_daf_exact import eth_daf_pkg::*; #(
   parameter int N_EXACT = 8,
   parameter int AW      = 6,
   parameter int CW      = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [AW-1:0]     cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic [DA_W-1:0]   da,
   input  logic [CW-1:0]     ucast_cnt,
   output logic [N_EXACT-1:0] hit_vec,
   output logic [N_EXACT-1:0] en_vec
);
   logic unused_wdata;
   assign unused_wdata = ^cfg_wdata[30:16];

   for (genvar i = 0; i < N_EXACT; i++) begin : g_slot
      localparam logic [AW-1:0] A_LO = AW'(ENTRY_BASE + 2*i);
      localparam logic [AW-1:0] A_HI = AW'(ENTRY_BASE + 2*i + 1);
      localparam logic [CW-1:0] SLOT = CW'(i);
      logic [DA_W-1:0] key;
      logic            en;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            key <= '0;
            en  <= 1'b0;
         end else if (cfg_we) begin
            if (cfg_addr == A_LO) key[31:0] <= cfg_wdata;
            if (cfg_addr == A_HI) begin
               key[47:32] <= cfg_wdata[15:0];
               en         <= cfg_wdata[31];
            end
         end
      end

      assign en_vec[i]  = en;
      assign hit_vec[i] = en && (key == da) && ((SLOT < ucast_cnt) || da[0]);
   end
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter import eth_daf_pkg::*; #(
   parameter int N_EXACT   = 8,
   parameter int HASH_W    = 6,
   parameter int AW        = 6,
   parameter int RESET_CNT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [31:0]      cfg_wdata,
   input  logic             da_valid,
   input  logic [47:0]      da,
   output logic             res_valid,
   output logic             res_accept,
   output logic [1:0]       res_reason
);
   localparam int TBL_BITS   = 2 ** HASH_W;
   localparam int HASH_WORDS = TBL_BITS / 32;
   localparam int CW         = CNT_W;

   if (N_EXACT < 1 || N_EXACT > 2**CW - 1) begin : g_bad_slots
      $error("N_EXACT out of range");
   end
   if (HASH_W < 6 || HASH_W > 9) begin : g_bad_hash
      $error("HASH_W out of range");
   end
   if (HASH_BASE + HASH_WORDS > ENTRY_BASE || ENTRY_BASE + 2*N_EXACT > 2**AW) begin : g_bad_map
      $error("register map does not fit AW");
   end
   if (RESET_CNT > N_EXACT) begin : g_bad_cnt
      $error("RESET_CNT above N_EXACT");
   end

   logic          promisc, hash_en, bcast_dis;
   logic [CW-1:0] ucast_cnt;
   logic [31:0]   hwords [HASH_WORDS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         promisc   <= 1'b0;
         hash_en   <= 1'b0;
         bcast_dis <= 1'b0;
         ucast_cnt <= CW'(RESET_CNT);
      end else if (cfg_we && cfg_addr == AW'(CTRL_ADDR)) begin
         promisc   <= cfg_wdata[0];
         hash_en   <= cfg_wdata[1];
         bcast_dis <= cfg_wdata[2];
         if (cfg_wdata[CNT_LSB +: CW] <= CW'(N_EXACT))
            ucast_cnt <= cfg_wdata[CNT_LSB +: CW];
      end
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < HASH_WORDS; w++) begin
         if (!rst_n)
            hwords[w] <= '0;
         else if (cfg_we && cfg_addr == AW'(HASH_BASE + w))
            hwords[w] <= cfg_wdata;
      end
   end

   logic [N_EXACT-1:0] hit_vec, en_vec;
   logic [HASH_W-1:0]  hidx;

   eth_daf_exact #(.N_EXACT(N_EXACT), .AW(AW), .CW(CW)) u_exact (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da(da), .ucast_cnt(ucast_cnt),
      .hit_vec(hit_vec), .en_vec(en_vec)
   );

   eth_daf_hash #(.ADDR_W(DA_W), .IDX_W(HASH_W)) u_hash (
      .da(da), .idx(hidx)
   );

   logic    is_bcast, is_mcast, hash_bit;
   reason_e verdict;

   assign is_bcast = &da;
   assign is_mcast = da[0];
   assign hash_bit = hwords[hidx[HASH_W-1:5]][hidx[4:0]];

   always_comb begin
      if (|hit_vec)
         verdict = RSN_EXACT;
      else if (is_bcast && !bcast_dis)
         verdict = RSN_OPEN;
      else if (is_mcast && !is_bcast && hash_en && hash_bit)
         verdict = RSN_HASH;
      else if (promisc)
         verdict = RSN_OPEN;
      else
         verdict = RSN_DROP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_reason <= RSN_DROP;
      end else begin
         res_valid  <= da_valid;
         res_accept <= da_valid && (verdict != RSN_DROP);
         res_reason <= da_valid ? verdict : RSN_DROP;
      end
   end
endmodule

// File: rtl/eth_daf_chk.sv
module eth_daf_chk #(
   parameter int N_EXACT = 8,
   parameter int CW      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               da_valid,
   input logic [47:0]        da,
   input logic               res_valid,
   input logic               res_accept,
   input logic [1:0]         res_reason,
   input logic [N_EXACT-1:0] hit_vec,
   input logic [N_EXACT-1:0] en_vec,
   input logic               promisc,
   input logic               bcast_dis,
   input logic [CW-1:0]      ucast_cnt
);
   logic started;
   always_ff @(posedge clk) begin
      if (!rst_n) started <= 1'b0;
      else        started <= 1'b1;
   end

   logic [N_EXACT-1:0] upper_mask;
   always_comb begin
      for (int i = 0; i < N_EXACT; i++)
         upper_mask[i] = (i >= int'(ucast_cnt));
   end

   assert_valid_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
      started |-> (res_valid == $past(da_valid)));

   assert_accept_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_accept == (res_valid && res_reason != 2'd0));

   assert_disabled_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_vec & ~en_vec) == '0);

   assert_mcast_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !da[0] |-> ((hit_vec & upper_mask) == '0));

   assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ucast_cnt) <= N_EXACT);

   assert_bcast_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(da_valid) && $past(&da) && $past(bcast_dis)
       && !$past(promisc) && ($past(hit_vec) == '0)) |-> !res_accept);

   assert_open_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(da_valid) && $past(promisc)) |-> res_accept);

   assert_slot_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (started && $past(da_valid) && $past(|hit_vec)) |-> (res_reason == 2'd1));
endmodule

bind eth_da_filter eth_daf_chk #(.N_EXACT(N_EXACT), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
   .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason),
   .hit_vec(hit_vec), .en_vec(en_vec), .promisc(promisc),
   .bcast_dis(bcast_dis), .ucast_cnt(ucast_cnt)
);

// File: tb/test_eth_da_filter.sv
module test_eth_da_filter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        res_valid, res_accept;
   logic [1:0]  res_reason;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   eth_da_filter i_eth_da_filter (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .da_valid(da_valid), .da(da),
      .res_valid(res_valid), .res_accept(res_accept), .res_reason(res_reason)
   );

   localparam logic [47:0] STATION = 48'h55_44_33_22_11_02;
   localparam logic [47:0] UC1     = 48'hEE_DD_CC_BB_AA_02;
   localparam logic [47:0] MC2     = 48'h01_00_00_5E_00_01;
   localparam logic [47:0] UC3     = 48'h77_00_00_00_00_02;
   localparam logic [47:0] MC_LO   = 48'h10_00_7F_5E_00_01; // fold index 12
   localparam logic [47:0] MC_HI   = 48'h80_00_00_00_00_01; // fold index 33
   localparam logic [47:0] MC_MISS = 48'h02_00_00_5E_00_01; // fold index 22
   localparam logic [47:0] BCAST   = 48'hFF_FF_FF_FF_FF_FF;
   localparam logic [47:0] UC_OTH  = 48'h56_44_33_22_11_02;

   typedef struct packed {
      logic [47:0] addr;
      logic [1:0]  rsn;
   } vec_t;

   localparam vec_t VECS [9] = '{
      '{STATION, 2'd1},  // R2 slot 0
      '{UC1,     2'd1},  // R2 R4 slot 1 unicast below count
      '{MC2,     2'd1},  // R2 slot 2 multicast
      '{UC3,     2'd0},  // R4 unicast in multicast-only slot
      '{MC_LO,   2'd2},  // R6 low word
      '{MC_HI,   2'd2},  // R6 high word
      '{MC_MISS, 2'd0},  // R6 unset bin
      '{BCAST,   2'd3},  // R7
      '{UC_OTH,  2'd0}   // R2 near miss
   };

   task automatic cfg(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic check_res(input logic [1:0] exp_rsn, input string tag);
      checks++;
      if (res_valid !== 1'b1 || res_reason !== exp_rsn || res_accept !== (exp_rsn != 2'd0)) begin
         errors++;
         $display("FAIL %s: valid=%b accept=%b reason=%0d expected valid=1 accept=%b reason=%0d",
                  tag, res_valid, res_accept, res_reason, exp_rsn != 2'd0, exp_rsn);
      end
   endtask

   task automatic lookup(input logic [47:0] a, input logic [1:0] exp_rsn, input string tag);
      @(negedge clk);
      da_valid = 1'b1; da = a;
      @(negedge clk);
      da_valid = 1'b0;
      check_res(exp_rsn, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: valid=%b accept=%b expected 0 0", res_valid, res_accept);
      end
      lookup(STATION, 2'd0, "R3 slots disabled at reset");
      lookup(BCAST, 2'd3, "R7 broadcast accepted at reset");
      cfg(6'h00, 32'h0000_0012);
      lookup(MC_LO, 2'd0, "R3 hash words zero at reset");

      // configuration: count 2, hash enable
      cfg(6'h00, 32'h0000_0022);
      cfg(6'h01, 32'h0000_1000);
      cfg(6'h02, 32'h0000_0002);
      cfg(6'h10, STATION[31:0]); cfg(6'h11, {16'h8000, STATION[47:32]});
      cfg(6'h12, UC1[31:0]);     cfg(6'h13, {16'h8000, UC1[47:32]});
      cfg(6'h14, MC2[31:0]);     cfg(6'h15, {16'h8000, MC2[47:32]});
      cfg(6'h16, UC3[31:0]);     cfg(6'h17, {16'h8000, UC3[47:32]});

      for (int v = 0; v < 9; v++)
         lookup(VECS[v].addr, VECS[v].rsn, $sformatf("table vec %0d (R2 R4 R6 R7)", v));

      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 idle: valid=%b expected 0", res_valid);
      end

      cfg(6'h00, 32'h0000_0026);
      lookup(BCAST, 2'd0, "R7 broadcast rejected");
      cfg(6'h00, 32'h0000_0027);
      lookup(BCAST, 2'd3, "R8 open mode overrides broadcast reject");
      lookup(MC_MISS, 2'd3, "R8 open mode accepts hash miss");
      lookup(STATION, 2'd1, "R9 slot hit ahead of open mode");
      cfg(6'h00, 32'h0000_0020);
      lookup(MC_LO, 2'd0, "R6 hash disabled");
      lookup(BCAST, 2'd3, "R9 broadcast ahead of hash");

      cfg(6'h00, 32'h0000_0022);
      cfg(6'h01, 32'hFFFF_FFFF);
      cfg(6'h02, 32'hFFFF_FFFF);
      lookup(MC_MISS, 2'd2, "R11 all-ones hash accepts multicast");
      lookup(UC_OTH, 2'd0, "R6 hash ignores unicast");

      cfg(6'h00, 32'h0000_0092);
      lookup(UC3, 2'd0, "R5 count above 8 ignored");
      cfg(6'h00, 32'h0000_0042);
      lookup(UC3, 2'd1, "R4 count raised to 4");

      // R10: lookup and disabling write on the same edge
      @(negedge clk);
      da_valid = 1'b1; da = UC1;
      cfg_we = 1'b1; cfg_addr = 6'h13; cfg_wdata = {16'h0000, UC1[47:32]};
      @(negedge clk);
      da_valid = 1'b0; cfg_we = 1'b0;
      check_res(2'd1, "R10 lookup uses old slot state");
      lookup(UC1, 2'd0, "R3 disabled slot no longer matches");

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule